// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the digital side of a small three-wire serial EEPROM. A host selects it with a chip select. It then clocks a command into the serial input on the rising edges of a serial clock. Each command begins with a start bit, followed by a two-bit opcode, an address and any write data. The block stores its contents in a register array inside the block. A strap input chooses the array shape: 128 bytes, or 64 words of 16 bits.

All inputs are sampled in a single system clock domain. The three pins pass through a synchroniser, and serial-clock rising edges are found by an edge detector. Programming commands are self-timed. One erase or write takes `PROG_CYCLES` system clocks, and the bulk commands take proportionally longer. While a program cycle runs, a host that drops the chip select and raises it again sees busy or ready on the serial output. The serial output is modelled as a data bit plus an output enable.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is off and every array bit reads as 1.
- R2: A frame starts at the first serial-clock rise that samples the serial input high while chip select is high. Any number of earlier rises with the input low are ignored.
- R3: The opcode is the two bits after the start bit, first bit in the MSB: 10 read, 01 write, 11 erase. For 00, the two most significant address bits form a sub-code: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R4: With the strap low, the array is 8 bits wide with a 7-bit byte address. An odd byte address maps to bits 15:8 of 16-bit word (address>>1), and an even one to bits 7:0. With the strap high, the array is 16 bits wide with a 6-bit address. All addresses and data are sent MSB first.
- R5: A read drives 0 on the output at the rise that carries the last address bit. Each following rise then presents the next data bit, MSB first, with the output enabled.
- R6: While the write-enable latch is off, write, erase, erase-all and write-all change nothing and start no program cycle.
- R7: A write replaces the addressed location. In byte mode, the other byte of the same word keeps its value.
- R8: Erase sets the addressed location to all ones. Erase-all sets the whole array to ones. Write-all stores the data in every location, or in every byte in byte mode.
- R9: A command whose frame is cut short by chip select going low has no effect.
- R10: During a program cycle, raising chip select after it was low enables the output and shows 0 while busy and 1 once ready. Chip select low disables the output.
- R11: Busy lasts `PROG_CYCLES` clocks for erase or write, 1.5 times that for erase-all, and 3 times that for write-all.
- R12: The disable command turns the write-enable latch off again, so later programming commands have no effect.
- R13: No start bit is accepted while a program cycle runs, so frames sent then are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| org_i | input | 1 | Shape strap: 0 = bytes, 1 = 16-bit words |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
Reads are tried in both shapes and after a string of leading zeros. This separates start detection from opcode decoding and the dummy bit from the data. A byte write into a word that already holds a 16-bit value is read back three ways. That shows whether the byte lane and the neighbour byte are handled correctly. The busy time is measured for a single write, an erase-all and a write-all. The three windows do not overlap, so a wrong duration multiplier cannot pass. Locked, disabled, truncated and collided frames are each followed by a read, which shows that the array was left alone.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes: opcode and sub-code values follow the command framing in the brief.
package eep_pkg;

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_WRITE, K_ERASE, K_EWEN, K_EWDS, K_ERAL, K_WRAL
    } eep_kind_e;

    typedef enum logic [2:0] {
        F_WAIT, F_OPC, F_ADDR, F_DATA, F_READ, F_DONE
    } eep_fst_e;

    // Map opcode and address sub-code to a command kind
    function automatic eep_kind_e eep_decode(input logic [1:0] opc, input logic [1:0] sub);
        eep_kind_e k;
        case (opc)
            2'b10:   k = K_READ;
            2'b01:   k = K_WRITE;
            2'b11:   k = K_ERASE;
            default: begin
                case (sub)
                    2'b11:   k = K_EWEN;
                    2'b00:   k = K_EWDS;
                    2'b10:   k = K_ERAL;
                    default: k = K_WRAL;
                endcase
            end
        endcase
        return k;
    endfunction

    // True for commands that start a self-timed program cycle
    function automatic logic eep_is_prog(input eep_kind_e k);
        return (k == K_WRITE) || (k == K_ERASE) || (k == K_ERAL) || (k == K_WRAL);
    endfunction

endpackage

// File: rtl/eep_sync.sv
// Input synchroniser and edge detector for chip select, serial clock and data.
// Assumes: the host changes data well before a serial-clock rise, so data and
// clock share the same pipeline depth and the data is stable at the detected edge.
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise,
    output logic cs_rise
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] sync_v;
    logic [NPIN-1:0] prev_v;

    assign raw = {cs_i, sclk_i, sdi_i};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [STAGES-1:0] pipe;
        // Shift the pin through a chain of flops
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], raw[i]};
        end
        assign sync_v[i] = pipe[STAGES-1];
    end

    // Remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_v <= '0;
        else        prev_v <= sync_v;
    end

    assign cs_s      = sync_v[2];
    assign sdi_s     = sync_v[0];
    assign sclk_rise = sync_v[1] & ~prev_v[1];
    assign cs_rise   = sync_v[2] & ~prev_v[2];

endmodule

// File: rtl/eep_prog_timer.sv
// Self-timed program cycle counter.
// Assumes: load is only raised while idle; len is the full duration in clocks.
module eep_prog_timer #(
    parameter int PROG_CYCLES = 200,
    localparam int TW = $clog2(3 * PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          busy,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Count the program cycle down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= len;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TW'(1));

    // R13
    timer_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R11
    timer_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len != '0) |=> busy);

endmodule

// File: rtl/eep_frame.sv
// Serial command framer: finds the start bit, shifts in opcode, address and
// write data, emits one execute pulse per complete frame and serialises reads.
// Assumes: inputs are already synchronised; rd_word is left aligned (a byte
// sits in bits 15:8) and reflects rd_addr combinationally.
module eep_frame #(
    parameter int WA16 = 6,
    localparam int WA8 = WA16 + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_s,
    input  logic                 sclk_rise,
    input  logic                 sdi_s,
    input  logic                 org_i,
    input  logic                 busy,
    input  logic [15:0]          rd_word,
    output logic [WA8-1:0]       rd_addr,
    output logic                 x16_o,
    output logic                 frame_start,
    output logic                 exec_v,
    output eep_pkg::eep_kind_e   exec_kind,
    output logic [WA8-1:0]       exec_addr,
    output logic [15:0]          exec_data,
    output logic                 rd_drive,
    output logic                 rd_bit
);
    import eep_pkg::*;

    eep_fst_e        st_q;
    logic [4:0]      cnt_q;
    logic [1:0]      op_q;
    logic [WA8-1:0]  addr_q;
    logic [15:0]     data_q;
    logic [15:0]     sh_q;
    logic            x16_q;
    eep_kind_e       kind_q;

    logic [WA8-1:0]  addr_nx;
    logic [15:0]     data_nx;
    logic [1:0]      sub_nx;
    logic [4:0]      aw_last;
    logic [4:0]      dw_last;
    eep_kind_e       kind_nx;

    // Next-value shifts and frame-length limits for the current shape
    always_comb begin
        addr_nx = {addr_q[WA8-2:0], sdi_s};
        data_nx = {data_q[14:0], sdi_s};
        sub_nx  = x16_q ? addr_nx[WA16-1 -: 2] : addr_nx[WA8-1 -: 2];
        aw_last = x16_q ? 5'(WA16 - 1) : 5'(WA8 - 1);
        dw_last = x16_q ? 5'd15 : 5'd7;
        kind_nx = eep_decode(op_q, sub_nx);
    end

    assign frame_start = cs_s && sclk_rise && (st_q == F_WAIT) && sdi_s && !busy;

    // Frame state machine, one step per serial-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= F_WAIT;
            cnt_q     <= '0;
            op_q      <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            sh_q      <= '0;
            x16_q     <= 1'b0;
            kind_q    <= K_NONE;
            exec_v    <= 1'b0;
            exec_kind <= K_NONE;
            exec_addr <= '0;
            exec_data <= '0;
            rd_drive  <= 1'b0;
            rd_bit    <= 1'b0;
        end else begin
            exec_v <= 1'b0;
            if (!cs_s) begin
                st_q     <= F_WAIT;
                rd_drive <= 1'b0;
            end else if (sclk_rise) begin
                case (st_q)
                    F_WAIT: begin
                        if (sdi_s && !busy) begin
                            st_q   <= F_OPC;
                            cnt_q  <= '0;
                            op_q   <= '0;
                            addr_q <= '0;
                            data_q <= '0;
                            x16_q  <= org_i;
                        end
                    end
                    F_OPC: begin
                        op_q <= {op_q[0], sdi_s};
                        if (cnt_q == 5'd1) begin
                            st_q  <= F_ADDR;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == aw_last) begin
                            cnt_q  <= '0;
                            kind_q <= kind_nx;
                            case (kind_nx)
                                K_READ: begin
                                    st_q     <= F_READ;
                                    rd_drive <= 1'b1;
                                    rd_bit   <= 1'b0;
                                end
                                K_WRITE, K_WRAL: st_q <= F_DATA;
                                default: begin
                                    exec_v    <= 1'b1;
                                    exec_kind <= kind_nx;
                                    exec_addr <= addr_nx;
                                    exec_data <= '0;
                                    st_q      <= F_DONE;
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_DATA: begin
                        data_q <= data_nx;
                        if (cnt_q == dw_last) begin
                            exec_v    <= 1'b1;
                            exec_kind <= kind_q;
                            exec_addr <= addr_q;
                            exec_data <= data_nx;
                            st_q      <= F_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    F_READ: begin
                        if (cnt_q == '0) begin
                            rd_bit <= rd_word[15];
                            sh_q   <= {rd_word[14:0], 1'b0};
                        end else begin
                            rd_bit <= sh_q[15];
                            sh_q   <= {sh_q[14:0], 1'b0};
                        end
                        if (cnt_q == dw_last) st_q  <= F_DONE;
                        else                  cnt_q <= cnt_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = addr_q;
    assign x16_o   = x16_q;

    // R9
    frame_exec_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_v |-> $past(cs_s) && $past(sclk_rise));

    // R5
    frame_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_drive) |-> !rd_bit);

endmodule

// File: rtl/ser_eeprom_slave.sv
// Three-wire serial EEPROM slave: register array, write-enable latch,
// self-timed programming and busy/ready status on the serial output.
// Assumes: the strap is static during a frame; all pins are asynchronous to clk.
module ser_eeprom_slave #(
    parameter int WORD_AW     = 6,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    import eep_pkg::*;

    localparam int WORDS   = 1 << WORD_AW;
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int TW      = $clog2(3 * PROG_CYCLES + 1);
    localparam logic [TW-1:0] LEN_ONE  = TW'(PROG_CYCLES);
    localparam logic [TW-1:0] LEN_BULK = TW'(PROG_CYCLES + PROG_CYCLES / 2);
    localparam logic [TW-1:0] LEN_ALL  = TW'(3 * PROG_CYCLES);

    logic               cs_s, sdi_s, sclk_rise, cs_rise;
    logic               busy, done;
    logic [15:0]        rd_word;
    logic [BYTE_AW-1:0] rd_addr;
    logic               x16;
    logic               frame_start;
    logic               exec_v;
    eep_kind_e          exec_kind;
    logic [BYTE_AW-1:0] exec_addr;
    logic [15:0]        exec_data;
    logic               rd_drive, rd_bit;

    logic [15:0]        mem [WORDS];
    logic               wen_q;
    logic               st_show_q;
    eep_kind_e          pend_kind;
    logic [BYTE_AW-1:0] pend_addr;
    logic [15:0]        pend_data;
    logic               pend_x16;
    logic               load;
    logic [TW-1:0]      len;
    logic [WORD_AW-1:0] rd_widx, pend_widx;
    logic [15:0]        rd_full, pend_full;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise), .cs_rise(cs_rise)
    );

    eep_frame #(.WA16(WORD_AW)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .sdi_s(sdi_s), .org_i(org_i), .busy(busy), .rd_word(rd_word),
        .rd_addr(rd_addr), .x16_o(x16), .frame_start(frame_start),
        .exec_v(exec_v), .exec_kind(exec_kind), .exec_addr(exec_addr),
        .exec_data(exec_data), .rd_drive(rd_drive), .rd_bit(rd_bit)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .len(len),
        .busy(busy), .done(done)
    );

    // Read path: select the word and left-align a byte in byte mode
    always_comb begin
        rd_widx = x16 ? rd_addr[WORD_AW-1:0] : rd_addr[BYTE_AW-1:1];
        rd_full = mem[rd_widx];
        if (x16)             rd_word = rd_full;
        else if (rd_addr[0]) rd_word = {rd_full[15:8], 8'h00};
        else                 rd_word = {rd_full[7:0], 8'h00};
    end

    // Program start request and its duration
    always_comb begin
        load = exec_v && eep_is_prog(exec_kind) && wen_q;
        case (exec_kind)
            K_ERAL:  len = LEN_BULK;
            K_WRAL:  len = LEN_ALL;
            default: len = LEN_ONE;
        endcase
    end

    // Write-enable latch and pending program command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q     <= 1'b0;
            pend_kind <= K_NONE;
            pend_addr <= '0;
            pend_data <= '0;
            pend_x16  <= 1'b0;
        end else if (exec_v) begin
            if (exec_kind == K_EWEN) wen_q <= 1'b1;
            if (exec_kind == K_EWDS) wen_q <= 1'b0;
            if (load) begin
                pend_kind <= exec_kind;
                pend_addr <= exec_addr;
                pend_data <= exec_data;
                pend_x16  <= x16;
            end
        end
    end

    // Target word of the pending command
    always_comb begin
        pend_widx = pend_x16 ? pend_addr[WORD_AW-1:0] : pend_addr[BYTE_AW-1:1];
        pend_full = mem[pend_widx];
    end

    // Array update at the end of the program cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        end else if (done) begin
            case (pend_kind)
                K_ERASE: begin
                    if (pend_x16)          mem[pend_widx] <= 16'hFFFF;
                    else if (pend_addr[0]) mem[pend_widx] <= {8'hFF, pend_full[7:0]};
                    else                   mem[pend_widx] <= {pend_full[15:8], 8'hFF};
                end
                K_WRITE: begin
                    if (pend_x16)          mem[pend_widx] <= pend_data;
                    else if (pend_addr[0]) mem[pend_widx] <= {pend_data[7:0], pend_full[7:0]};
                    else                   mem[pend_widx] <= {pend_full[15:8], pend_data[7:0]};
                end
                K_ERAL: begin
                    for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
                end
                K_WRAL: begin
                    for (int i = 0; i < WORDS; i++)
                        mem[i] <= pend_x16 ? pend_data : {pend_data[7:0], pend_data[7:0]};
                end
                default: ;
            endcase
        end
    end

    // Status display: armed by a chip-select rise during a program cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                  st_show_q <= 1'b0;
        else if (!cs_s)              st_show_q <= 1'b0;
        else if (frame_start)        st_show_q <= 1'b0;
        else if (cs_rise && busy)    st_show_q <= 1'b1;
    end

    assign sdo_oe_o = cs_s && (st_show_q || rd_drive);
    assign sdo_o    = st_show_q ? !busy : rd_bit;

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sdo_oe_o && !wen_q));

    // R6
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_v && eep_is_prog(exec_kind) && !wen_q && !busy) |=> !busy);

    // R10
    status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_show_q && busy && cs_s) |-> (sdo_oe_o && !sdo_o));

    // R10
    cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_s) |=> !sdo_oe_o);

endmodule

// File: tb/sim_ser_eeprom_slave.sv
module sim_ser_eeprom_slave;
    localparam int P = 200;

    logic clk = 1'b0;
    logic rst_n, cs, sclk, sdi, org;
    logic sdo, sdo_oe;
    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;

    always #2 clk = ~clk;

    ser_eeprom_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
        .org_i(org), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs = 1'b0;
        sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic hdr(input logic [1:0] op, input logic x16, input logic [6:0] a, input int pre);
        org = x16;
        cs = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < pre; i++) bit_out(1'b0);
        bit_out(1'b1);
        send({30'd0, op}, 2);
        send({25'd0, a}, x16 ? 6 : 7);
    endtask

    task automatic ctrl(input logic [1:0] sub, input logic x16);
        hdr(2'b00, x16, x16 ? {1'b0, sub, 4'b0} : {sub, 5'b0}, 0);
    endtask

    task automatic do_read(input logic x16, input logic [6:0] a, input int pre,
                           output logic [15:0] d);
        int dw;
        dw = x16 ? 16 : 8;
        d = '0;
        hdr(2'b10, x16, a, pre);
        chk("R5 dummy bit", {30'd0, sdo_oe, sdo}, 32'd2);
        for (int i = dw - 1; i >= 0; i--) begin
            bit_out(1'b0);
            d[i] = sdo;
        end
        cs_low();
    endtask

    task automatic do_write(input logic x16, input logic [6:0] a, input logic [15:0] d);
        hdr(2'b01, x16, a, 0);
        send({16'd0, d}, x16 ? 16 : 8);
    endtask

    task automatic wait_ready(output int n, output logic saw_busy);
        cs_low();
        cs = 1'b1;
        repeat (4) @(negedge clk);
        saw_busy = sdo_oe && !sdo;
        n = 4;
        while (!(sdo_oe === 1'b1 && sdo === 1'b1) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        cs_low();
    endtask

    task automatic expect_idle(input string req);
        cs_low();
        cs = 1'b1;
        repeat (6) @(negedge clk);
        chk(req, {31'd0, sdo_oe}, 32'd0);
        cs_low();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
        do_read(1'b1, 7'd5, 0, d);
        chk("R1 erased after reset", {16'd0, d}, 32'h0000FFFF);
    endtask

    task automatic t_locked();
        logic [15:0] d;
        do_write(1'b1, 7'd3, 16'h1234);
        expect_idle("R6 no busy while locked");
        do_read(1'b1, 7'd3, 0, d);
        chk("R6 locked write ignored", {16'd0, d}, 32'h0000FFFF);
    endtask

    task automatic t_write16();
        logic [15:0] d;
        int n;
        logic sb;
        ctrl(2'b11, 1'b1);
        cs_low();
        do_write(1'b1, 7'd3, 16'h1234);
        wait_ready(n, sb);
        chk("R10 busy shown as 0", {31'd0, sb}, 32'd1);
        chk_rng("R11 write duration", n, P - 40, P + 5);
        do_read(1'b1, 7'd3, 5, d);
        chk("R2 R3 R7 read after leading zeros", {16'd0, d}, 32'h00001234);
    endtask

    task automatic t_write8();
        logic [15:0] d;
        int n;
        logic sb;
        do_write(1'b0, 7'd7, 16'h00A5);
        wait_ready(n, sb);
        do_read(1'b0, 7'd7, 0, d);
        chk("R7 byte written", {16'd0, d}, 32'h000000A5);
        do_read(1'b0, 7'd6, 0, d);
        chk("R7 neighbour byte kept", {16'd0, d}, 32'h00000034);
        do_read(1'b1, 7'd3, 0, d);
        chk("R4 odd byte is high lane", {16'd0, d}, 32'h0000A534);
    endtask

    task automatic t_erase();
        logic [15:0] d;
        int n;
        logic sb;
        hdr(2'b11, 1'b1, 7'd3, 0);
        wait_ready(n, sb);
        chk_rng("R11 erase duration", n, P - 40, P + 5);
        do_read(1'b1, 7'd3, 0, d);
        chk("R8 erase to ones", {16'd0, d}, 32'h0000FFFF);
    endtask

    task automatic t_cs_quiet();
        int n;
        logic sb;
        do_write(1'b1, 7'd4, 16'h0F0F);
        cs_low();
        repeat (4) @(negedge clk);
        chk("R10 output off with cs low", {31'd0, sdo_oe}, 32'd0);
        wait_ready(n, sb);
        chk_rng("R10 ready shown as 1", n, 4, 4999);
    endtask

    task automatic t_trunc();
        logic [15:0] d;
        hdr(2'b01, 1'b1, 7'd8, 0);
        send(32'h3FF, 10);
        expect_idle("R9 truncated frame no busy");
        do_read(1'b1, 7'd8, 0, d);
        chk("R9 truncated frame no write", {16'd0, d}, 32'h0000FFFF);
    endtask

    task automatic t_eral();
        logic [15:0] d;
        int n;
        logic sb;
        ctrl(2'b10, 1'b1);
        wait_ready(n, sb);
        chk_rng("R11 erase-all duration", n, P + P / 2 - 40, P + P / 2 + 5);
        do_read(1'b1, 7'd4, 0, d);
        chk("R8 erase-all", {16'd0, d}, 32'h0000FFFF);
    endtask

    task automatic t_wral();
        logic [15:0] d;
        int n;
        logic sb;
        ctrl(2'b01, 1'b1);
        send(32'h5A5A, 16);
        wait_ready(n, sb);
        chk_rng("R11 write-all duration", n, 3 * P - 40, 3 * P + 5);
        do_read(1'b1, 7'd0, 0, d);
        chk("R8 write-all first", {16'd0, d}, 32'h00005A5A);
        do_read(1'b1, 7'd63, 0, d);
        chk("R8 write-all last", {16'd0, d}, 32'h00005A5A);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] d;
        int n;
        logic sb;
        ctrl(2'b01, 1'b1);
        send(32'h1111, 16);
        cs_low();
        do_write(1'b1, 7'd11, 16'h2222);
        wait_ready(n, sb);
        chk_rng("R13 ready reached", n, 4, 4999);
        do_read(1'b1, 7'd11, 0, d);
        chk("R13 frame during busy dropped", {16'd0, d}, 32'h00001111);
    endtask

    task automatic t_ewds();
        logic [15:0] d;
        ctrl(2'b00, 1'b1);
        cs_low();
        do_write(1'b1, 7'd12, 16'h7777);
        expect_idle("R12 no busy after disable");
        do_read(1'b1, 7'd12, 0, d);
        chk("R12 write after disable ignored", {16'd0, d}, 32'h00001111);
    endtask

    initial begin
        rst_n = 1'b0; cs = 1'b0; sclk = 1'b0; sdi = 1'b0; org = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_locked();
        t_write16();
        t_write8();
        t_erase();
        t_cs_quiet();
        t_trunc();
        t_eral();
        t_wral();
        t_busy_ignore();
        t_ewds();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule